// File: doc/BRIEF.md
# CAN Controller Status and Interrupt Registers

This block holds the read-only status byte and the interrupt byte of a simple CAN controller's CPU interface. The protocol engine, the error counters and the receive FIFO sit outside it and reach it as plain level and pulse inputs. From these inputs the block keeps eight status flags. Four of them are derived with their own state: the receive-buffer flag, the deferred overrun flag, the transmit-buffer lock and transmission-complete. The other four are registered copies of engine levels.

The interrupt byte is built from edges and levels of the status flags. Each bit is gated by an enable bit from the control register. A CPU read of the interrupt address clears the event bits. The receive bit clears only on the release-receive-buffer command. A single interrupt request line is the OR of the live interrupt bits. A combinational read port returns the status byte at address 2 and the interrupt byte at address 3. No write path reaches either byte.

Top module: `can_sir_regs`

## Requirements
- R1: Status bit 0 follows "receive FIFO not empty" one cycle later. In the cycle after a release command it is 0. It returns to 1 on the next cycle if the FIFO is still not empty.
- R2: A drop pulse does not set status bit 1 while the FIFO is not empty. It sets bit 1 on the first edge at which the FIFO reads empty. A clear-overrun command returns bit 1 to 0.
- R3: Status bit 2 (transmit buffer free) is 0 from the edge after a transmission request. It stays 0 while the transmitter is busy. It returns to 1 on the edge after busy falls or on a success pulse.
- R4: Status bit 3 (transmission complete) is 0 from the edge after a transmission request. It stays 0 until a success pulse sets it to 1.
- R5: Status bits 4, 5 and 7 are registered copies of receiving, transmitting and bus-off. Bit 6 is 1 when either error counter is at or above 96.
- R6: An interrupt bit 0..3 never becomes 1 while its enable bit ie[n] is 0.
- R7: Interrupt set rules, in the same cycle as the status change. Bit 0 equals status bit 0 when enabled. Bit 1 sets on a 0-to-1 change of status bit 2. Bit 2 sets on any change of status bit 6 or 7. Bit 3 sets on a 0-to-1 change of status bit 1.
- R8: A read strobe at address 3 clears interrupt bits 1..3 on the next edge but leaves bit 0. A set event in the same cycle wins over the clear.
- R9: Interrupt bit 0 is 0 in the cycle after a release command.
- R10: Interrupt byte bits 7..5 always read 1, and bit 4 always reads 0.
- R11: With the read strobe high, the read data returns the status byte at address 2 and the interrupt byte at address 3. It returns 0 at any other address or with the strobe low.
- R12: The interrupt line is 1 exactly when any of interrupt bits 0..3 is 1.
- R13: After reset the status byte is 0x0C and the interrupt byte is 0xE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxq_nonempty | input | 1 | Receive FIFO holds at least one message |
| rxq_drop | input | 1 | Pulse: an accepted message was dropped, FIFO full |
| rx_busy | input | 1 | Engine is receiving a frame |
| tx_busy | input | 1 | Engine is transmitting a frame |
| tx_ok | input | 1 | Pulse: frame sent successfully |
| bus_off | input | 1 | Node is bus-off |
| tec | input | CNT_W | Transmit error counter |
| rec | input | CNT_W | Receive error counter |
| ie | input | 4 | Interrupt enables for bits 0..3 |
| cmd_release | input | 1 | Pulse: release receive buffer |
| cmd_txreq | input | 1 | Pulse: transmission request |
| cmd_clr_ovr | input | 1 | Pulse: clear overrun |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Read data |
| status_byte | output | 8 | Status register |
| irq_byte | output | 8 | Interrupt register |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that command and event inputs are one-cycle pulses driven between clock edges. They also assume that a transmission request arrives only while the transmit buffer is free. The bench applies every stimulus at a fixed offset after the rising edge and holds it for exactly one cycle. It never issues a request while a transmission is still locked. The error counters are swept through all 256 values each, and every status level input is toggled with interrupts masked and then unmasked, so that both the gating and the set rules are observed.

// File: rtl/can_sir_pkg.sv
package can_sir_pkg;
    localparam int SR_RXBUF = 0;
    localparam int SR_OVR   = 1;
    localparam int SR_TXBUF = 2;
    localparam int SR_TCOMP = 3;
    localparam int SR_RXING = 4;
    localparam int SR_TXING = 5;
    localparam int SR_ERR   = 6;
    localparam int SR_BOFF  = 7;
    localparam int IRQ_N    = 4;

    typedef struct packed {
        logic [7:0]       sr;
        logic [IRQ_N-1:0] ir;
        logic             ovr_pend;
        logic             tx_lock;
        logic             busy_prev;
    } sir_state_t;
endpackage

// File: rtl/can_sir_status.sv
module can_sir_status
    import can_sir_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int WARN_LIM = 96
) (
    input  logic [7:0]       sr_q,
    input  logic             pend_q,
    input  logic             lock_q,
    input  logic             busy_prev_q,
    input  logic             rxq_nonempty,
    input  logic             rxq_drop,
    input  logic             rx_busy,
    input  logic             tx_busy,
    input  logic             tx_ok,
    input  logic             bus_off,
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    input  logic             cmd_release,
    input  logic             cmd_txreq,
    input  logic             cmd_clr_ovr,
    output logic [7:0]       sr_d,
    output logic             pend_d,
    output logic             lock_d,
    output logic             busy_prev_d
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(WARN_LIM);

    logic busy_fall;
    logic promote;

    always_comb begin
        busy_fall   = busy_prev_q & ~tx_busy;
        promote     = pend_q & ~rxq_nonempty;
        lock_d      = cmd_txreq | (lock_q & ~busy_fall & ~tx_ok);
        pend_d      = rxq_drop | (pend_q & ~promote & ~cmd_clr_ovr);
        busy_prev_d = tx_busy;

        sr_d           = sr_q;
        sr_d[SR_RXBUF] = ~cmd_release & rxq_nonempty;
        sr_d[SR_OVR]   = ~cmd_clr_ovr & (sr_q[SR_OVR] | promote);
        sr_d[SR_TXBUF] = ~(lock_d | tx_busy);
        if (cmd_txreq)
            sr_d[SR_TCOMP] = 1'b0;
        else if (tx_ok)
            sr_d[SR_TCOMP] = 1'b1;
        sr_d[SR_RXING] = rx_busy;
        sr_d[SR_TXING] = tx_busy;
        sr_d[SR_ERR]   = (tec >= LIM) | (rec >= LIM);
        sr_d[SR_BOFF]  = bus_off;
    end
endmodule

// File: rtl/can_sir_irq.sv
module can_sir_irq
    import can_sir_pkg::*;
(
    input  logic [7:0]       sr_q,
    input  logic [7:0]       sr_d,
    input  logic [IRQ_N-1:0] ir_q,
    input  logic [IRQ_N-1:0] ie,
    input  logic             rd_clr,
    output logic [IRQ_N-1:0] ir_d
);
    logic [IRQ_N-1:0] set_ev;

    always_comb begin
        set_ev    = '0;
        set_ev[1] = ~sr_q[SR_TXBUF] & sr_d[SR_TXBUF];
        set_ev[2] = (sr_q[SR_ERR] ^ sr_d[SR_ERR]) | (sr_q[SR_BOFF] ^ sr_d[SR_BOFF]);
        set_ev[3] = ~sr_q[SR_OVR] & sr_d[SR_OVR];
    end

    assign ir_d[0] = ie[0] & sr_d[SR_RXBUF];

    for (genvar i = 1; i < IRQ_N; i++) begin : g_evt
        assign ir_d[i] = (ie[i] & set_ev[i]) | (ir_q[i] & ~rd_clr);
    end
endmodule

// File: rtl/can_sir_regs.sv
module can_sir_regs
    import can_sir_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int WARN_LIM = 96,
    parameter int ADDR_W   = 5,
    parameter int SR_ADDR  = 2,
    parameter int IR_ADDR  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxq_nonempty,
    input  logic              rxq_drop,
    input  logic              rx_busy,
    input  logic              tx_busy,
    input  logic              tx_ok,
    input  logic              bus_off,
    input  logic [CNT_W-1:0]  tec,
    input  logic [CNT_W-1:0]  rec,
    input  logic [3:0]        ie,
    input  logic              cmd_release,
    input  logic              cmd_txreq,
    input  logic              cmd_clr_ovr,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [7:0]        status_byte,
    output logic [7:0]        irq_byte,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_SR = ADDR_W'(SR_ADDR);
    localparam logic [ADDR_W-1:0] A_IR = ADDR_W'(IR_ADDR);
    localparam logic [3:0]        IR_FIXED_HI = 4'b1110;

    sir_state_t st_q, st_d;

    logic [7:0]       sr_n;
    logic             pend_n, lock_n, bprev_n;
    logic [IRQ_N-1:0] ir_n;
    logic             rd_clr;

    assign rd_clr = rd_en & (rd_addr == A_IR);

    can_sir_status #(.CNT_W(CNT_W), .WARN_LIM(WARN_LIM)) u_status (
        .sr_q(st_q.sr), .pend_q(st_q.ovr_pend), .lock_q(st_q.tx_lock),
        .busy_prev_q(st_q.busy_prev),
        .rxq_nonempty(rxq_nonempty), .rxq_drop(rxq_drop),
        .rx_busy(rx_busy), .tx_busy(tx_busy), .tx_ok(tx_ok),
        .bus_off(bus_off), .tec(tec), .rec(rec),
        .cmd_release(cmd_release), .cmd_txreq(cmd_txreq), .cmd_clr_ovr(cmd_clr_ovr),
        .sr_d(sr_n), .pend_d(pend_n), .lock_d(lock_n), .busy_prev_d(bprev_n)
    );

    can_sir_irq u_irq (
        .sr_q(st_q.sr), .sr_d(sr_n), .ir_q(st_q.ir), .ie(ie),
        .rd_clr(rd_clr), .ir_d(ir_n)
    );

    always_comb begin
        st_d           = st_q;
        st_d.sr        = sr_n;
        st_d.ir        = ir_n;
        st_d.ovr_pend  = pend_n;
        st_d.tx_lock   = lock_n;
        st_d.busy_prev = bprev_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q              <= '0;
            st_q.sr[SR_TXBUF] <= 1'b1;
            st_q.sr[SR_TCOMP] <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_byte = st_q.sr;
        irq_byte    = {IR_FIXED_HI, st_q.ir};
        irq         = |st_q.ir;
        rd_data     = '0;
        if (rd_en && rd_addr == A_SR)
            rd_data = status_byte;
        else if (rd_en && rd_addr == A_IR)
            rd_data = irq_byte;
    end
endmodule

// File: rtl/can_sir_chk.sv
module can_sir_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rxq_nonempty,
    input logic       tx_busy,
    input logic       cmd_release,
    input logic       cmd_txreq,
    input logic [3:0] ie,
    input logic [7:0] status_byte,
    input logic [7:0] irq_byte,
    input logic       irq
);
    p_rxbuf_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_release |=> !status_byte[0]);
    p_rxbuf_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_release && rxq_nonempty) |=> status_byte[0]);
    p_ovr_deferred_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_byte[1] && rxq_nonempty) |=> !status_byte[1]);
    p_txbuf_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy || cmd_txreq) |=> !status_byte[2]);
    p_tcomp_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_txreq |=> !status_byte[3]);
    p_gate_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ie[1] |=> !$rose(irq_byte[1]));
    p_gate_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ie[3] |=> !$rose(irq_byte[3]));
    p_ir0_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_release |=> !irq_byte[0]);
    p_fixed_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_byte[7:4] == 4'b1110);
    p_irq_line_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_byte[3:0] != 4'b0000));
endmodule

bind can_sir_regs can_sir_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rxq_nonempty(rxq_nonempty), .tx_busy(tx_busy),
    .cmd_release(cmd_release), .cmd_txreq(cmd_txreq), .ie(ie),
    .status_byte(status_byte), .irq_byte(irq_byte), .irq(irq)
);

// File: tb/tb_can_sir_regs.sv
module tb_can_sir_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxq_nonempty = 0, rxq_drop = 0, rx_busy = 0, tx_busy = 0;
    logic       tx_ok = 0, bus_off = 0;
    logic [7:0] tec = 0, rec = 0;
    logic [3:0] ie = 0;
    logic       cmd_release = 0, cmd_txreq = 0, cmd_clr_ovr = 0;
    logic       rd_en = 0;
    logic [4:0] rd_addr = 0;
    logic [7:0] rd_data, status_byte, irq_byte;
    logic       irq;
    int         n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    can_sir_regs dut (
        .clk(clk), .rst_n(rst_n), .rxq_nonempty(rxq_nonempty), .rxq_drop(rxq_drop),
        .rx_busy(rx_busy), .tx_busy(tx_busy), .tx_ok(tx_ok), .bus_off(bus_off),
        .tec(tec), .rec(rec), .ie(ie), .cmd_release(cmd_release),
        .cmd_txreq(cmd_txreq), .cmd_clr_ovr(cmd_clr_ovr), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .status_byte(status_byte),
        .irq_byte(irq_byte), .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // advance one edge, clear pulses, land 2 ns after the edge
    task automatic step();
        @(posedge clk);
        #2;
        rxq_drop = 0; tx_ok = 0; cmd_release = 0; cmd_txreq = 0;
        cmd_clr_ovr = 0; rd_en = 0;
    endtask

    task automatic read_ir();
        rd_en = 1; rd_addr = 5'd3;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1;
        // R13 R10 R12 reset state
        chk(status_byte, 8'h0C, "R13 status");
        chk(irq_byte, 8'hE0, "R13 R10 irq byte");
        chk({7'd0, irq}, 8'd0, "R12 line at reset");

        // R5 error counter sweeps, interrupts masked
        for (int v = 0; v < 256; v++) begin
            tec = 8'(v); step();
            chk({7'd0, status_byte[6]}, {7'd0, v >= 96}, "R5 tec sweep");
        end
        tec = 0;
        for (int v = 0; v < 256; v++) begin
            rec = 8'(v); step();
            chk({7'd0, status_byte[6]}, {7'd0, v >= 96}, "R5 rec sweep");
        end
        rec = 0; step();
        // R5 level copies, all 8 combinations
        for (int k = 0; k < 8; k++) begin
            rx_busy = k[0]; tx_busy = k[1]; bus_off = k[2]; step();
            chk({status_byte[7], status_byte[5], status_byte[4]}, 8'(k[2:0] & 3'b111) == 0 ? 8'd0 : {k[2], k[1], k[0]}, "R5 levels");
        end
        rx_busy = 0; tx_busy = 0; bus_off = 0; step();
        chk({7'd0, irq}, 8'd0, "R6 masked events");
        chk(irq_byte, 8'hE0, "R6 masked byte");

        // R1 receive buffer status
        rxq_nonempty = 1; step();
        chk({7'd0, status_byte[0]}, 8'd1, "R1 nonempty");
        cmd_release = 1; step();
        chk({7'd0, status_byte[0]}, 8'd0, "R1 after release");
        step();
        chk({7'd0, status_byte[0]}, 8'd1, "R1 refill");
        rxq_nonempty = 0; step();
        chk({7'd0, status_byte[0]}, 8'd0, "R1 empty");

        // R2 deferred overrun, R7 overrun interrupt
        ie = 4'b1000;
        rxq_nonempty = 1; rxq_drop = 1; step();
        for (int k = 0; k < 4; k++) begin
            step();
            chk({7'd0, status_byte[1]}, 8'd0, "R2 hidden while nonempty");
        end
        rxq_nonempty = 0; step();
        chk({7'd0, status_byte[1]}, 8'd1, "R2 visible after drain");
        chk({7'd0, irq_byte[3]}, 8'd1, "R7 overrun irq");
        chk({7'd0, irq}, 8'd1, "R12 line with ir3");
        cmd_clr_ovr = 1; step();
        chk({7'd0, status_byte[1]}, 8'd0, "R2 cleared");
        read_ir();
        chk(irq_byte, 8'hE0, "R8 read clears ir3");
        chk({7'd0, irq}, 8'd0, "R12 line low");

        // R3 R4 transmit path with ie[1]
        ie = 4'b0010;
        cmd_txreq = 1; step();
        chk({6'd0, status_byte[3:2]}, 8'd0, "R3 R4 after request");
        tx_busy = 1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk({6'd0, status_byte[3:2]}, 8'd0, "R3 R4 busy");
        end
        tx_busy = 0; step();
        chk({7'd0, status_byte[2]}, 8'd1, "R3 freed after busy");
        chk({7'd0, status_byte[3]}, 8'd0, "R4 no success yet");
        chk({7'd0, irq_byte[1]}, 8'd1, "R7 tx buffer irq");
        tx_ok = 1; step();
        chk({7'd0, status_byte[3]}, 8'd1, "R4 success");
        read_ir();
        chk({7'd0, irq_byte[1]}, 8'd0, "R8 clears ir1");
        // R6 same sequence masked
        ie = 4'b0000;
        cmd_txreq = 1; step(); tx_busy = 1; step(); tx_busy = 0; step();
        chk({7'd0, status_byte[2]}, 8'd1, "R6 buffer freed");
        chk({7'd0, irq_byte[1]}, 8'd0, "R6 ir1 masked");
        // R3 request released by success pulse alone
        cmd_txreq = 1; step();
        chk({7'd0, status_byte[2]}, 8'd0, "R3 locked");
        tx_ok = 1; step();
        chk({7'd0, status_byte[2]}, 8'd1, "R3 released by success");

        // R7 error interrupt, R8 read clear keeps ir0, set wins
        ie = 4'b0101;
        rxq_nonempty = 1; step();
        chk({7'd0, irq_byte[0]}, 8'd1, "R7 rx irq");
        bus_off = 1; step();
        chk({7'd0, irq_byte[2]}, 8'd1, "R7 bus-off change irq");
        // R11 read port
        rd_en = 1; rd_addr = 5'd2; #1;
        chk(rd_data, status_byte, "R11 addr 2");
        rd_addr = 5'd3; #1;
        chk(rd_data, 8'hE5, "R11 addr 3");
        rd_addr = 5'd4; #1;
        chk(rd_data, 8'h00, "R11 other addr");
        rd_en = 0; rd_addr = 5'd2; #1;
        chk(rd_data, 8'h00, "R11 strobe low");
        read_ir();
        chk(irq_byte, 8'hE1, "R8 clears ir2 keeps ir0");
        bus_off = 0; rd_en = 1; rd_addr = 5'd3; step();
        chk(irq_byte, 8'hE5, "R8 set wins over read");
        tec = 8'd100; step();
        chk({7'd0, irq_byte[2]}, 8'd1, "R7 error status change");
        read_ir();
        // R9 release clears ir0
        cmd_release = 1; step();
        chk(irq_byte, 8'hE0, "R9 release clears ir0");
        chk({7'd0, irq}, 8'd0, "R12 line after release");
        step();
        chk({7'd0, irq_byte[0]}, 8'd1, "R7 ir0 back while nonempty");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule